// File: doc/BRIEF.md
# Concatenation-Incrementation Carry Skip Adder

This block is a purely combinational two-operand binary adder with a carry input. It is split into a configurable number of stages. The lowest stage is an ordinary ripple chain that takes the external carry. Every higher stage adds its operand slice on its own, with a carry of zero. It then folds the carry arriving from below into that intermediate result through a chain of half adders.

Carries between stages never ripple through the adder cells. Each stage forms its outgoing carry in one compound gate, from its own generated carry, the AND of its per-bit propagate terms and the incoming carry. The gates alternate between AND-OR-invert and OR-AND-invert. As a result the inter-stage carry is in true form at every other boundary and complemented at the rest, and no inverter sits on the carry path. The sum and carry-out at the ports are always in true form.

Stage widths are given as a packed list of 8-bit fields, with stage 0 in the lowest field. This allows equal-size and unequal-size layouts. The default is a 32-bit adder of eight 4-bit stages.

Top module: `cska_adder`

## Requirements
- R1: For every operand pair and carry input, {carryOut, sumOut} equals addA + addB + carryIn in the default 32-bit, eight-stage configuration.
- R2: Stage widths come from the STAGE_SIZES parameter (field k holds the width of stage k, stage 0 in the least significant byte). Any list whose widths total DATA_W gives an exact sum, including unequal widths.
- R3: The carry leaving each stage equals the stage's own generated carry, or the incoming carry when every bit of the stage propagates. A carry made in a low stage therefore reaches the first non-propagating stage above it.
- R4: When addA XOR addB is all ones, sumOut is all ones and carryOut is 0 for carryIn = 0, and sumOut is all zeros and carryOut is 1 for carryIn = 1.
- R5: With both operands zero, sumOut equals carryIn (zero-extended) and carryOut is 0.
- R6: With both operands all ones, carryOut is 1 and sumOut is all ones except bit 0, which equals carryIn.
- R7: carryOut and sumOut are in true polarity whether the number of stages is even or odd.
- R8: In a stage after the first, an incoming carry is added to the stage's intermediate sum through the incrementer and may ripple across the whole slice (for example 0x7F + 0x01 = 0x80). The incrementer's own overflow never affects the stage's outgoing carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addA | input | DATA_W | First operand |
| addB | input | DATA_W | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | DATA_W | Sum, true polarity |
| carryOut | output | 1 | Carry out of the top bit, true polarity |

## Verification
A 7-bit, three-stage instance with unequal widths is swept over every operand pair and both carry values. This covers every combination of generate, propagate and skip at each boundary, and also a stage count of odd parity. Random vectors on the 32-bit even-count instance and on a 128-bit seven-stage variable-width instance expose slice-offset and polarity faults that only wide layouts reach. Directed patterns split the cases apart. All-propagate operands isolate the skip path from the ripple path. Zero and all-ones operands pin the no-carry and always-generate extremes. A carry generated low and carried across propagating stages into a partial slice exercises the incrementer ripple on its own.

// File: rtl/cska_pkg.sv
package cska_pkg;

  // Flavour of the compound gate used as a stage's skip logic.
  typedef enum logic {
    SKIP_AOI = 1'b0,   // takes a true carry, returns a complemented one
    SKIP_OAI = 1'b1    // takes a complemented carry, returns a true one
  } skip_kind_e;

  // What a ripple block reports to its skip gate.
  typedef struct packed {
    logic gen;      // carry out of the stage's own ripple chain
    logic allProp;  // every bit of the slice propagates
  } stage_status_t;

  localparam int SIZE_FIELD_W = 8;

endpackage

// File: rtl/cska_ripple_block.sv
module cska_ripple_block
  import cska_pkg::*;
#(
  parameter int W       = 4,
  parameter bit HAS_CIN = 1'b0
) (
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          carryIn,
  output logic [W-1:0]  sumInt,
  output stage_status_t status
);

  logic [W-1:0] bitProp;
  logic [W-1:0] bitGen;
  logic [W:1]   chain;

  assign bitProp = opA ^ opB;
  assign bitGen  = opA & opB;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_first
      if (HAS_CIN) begin : g_fa
        assign sumInt[0] = bitProp[0] ^ carryIn;
        assign chain[1]  = bitGen[0] | (bitProp[0] & carryIn);
      end else begin : g_ha
        logic unusedCarryIn;
        assign unusedCarryIn = carryIn;
        assign sumInt[0] = bitProp[0];
        assign chain[1]  = bitGen[0];
      end
    end else begin : g_fa_rest
      assign sumInt[i]  = bitProp[i] ^ chain[i];
      assign chain[i+1] = bitGen[i] | (bitProp[i] & chain[i]);
    end
  end

  assign status.gen     = chain[W];
  assign status.allProp = &bitProp;

  // R3: a zero-carry-in slice cannot both generate and fully propagate
  if (!HAS_CIN) begin : g_chk
    always_comb begin
      if (!$isunknown({opA, opB})) begin
        a_r3_gen_excludes_prop: assert (!(status.gen && status.allProp))
          else $error("zero-carry slice generated while fully propagating");
      end
    end
  end

endmodule

// File: rtl/cska_incr_block.sv
module cska_incr_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] sumInt,
  input  logic         carryIn,
  output logic [W-1:0] sumOut
);

  // Half-adder chain; the carry out of the top cell is never formed.
  logic [W-1:0] hop;

  assign hop[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign sumOut[i] = sumInt[i] ^ hop[i];
    if (i < W - 1) begin : g_link
      assign hop[i+1] = sumInt[i] & hop[i];
    end
  end

  // R8: zero carry leaves the slice alone, a one adds exactly one
  always_comb begin
    if (!$isunknown({sumInt, carryIn})) begin
      if (!carryIn) begin
        a_r8_incr_idle: assert (sumOut == sumInt)
          else $error("incrementer changed slice without carry");
      end else begin
        a_r8_incr_step: assert (sumOut == W'(sumInt + 1'b1))
          else $error("incrementer did not add one");
      end
    end
  end

endmodule

// File: rtl/cska_skip_gate.sv
module cska_skip_gate
  import cska_pkg::*;
#(
  parameter skip_kind_e KIND = SKIP_AOI
) (
  input  stage_status_t status,
  input  logic          carryLink,
  output logic          carryNext
);

  if (KIND == SKIP_AOI) begin : g_aoi
    assign carryNext = ~(status.gen | (status.allProp & carryLink));
  end else begin : g_oai
    assign carryNext = ~(~status.gen & (~status.allProp | carryLink));
  end

  // R3: a fully propagating slice hands the carry on, inverted;
  // a generating slice forces the carry in this gate's output polarity
  always_comb begin
    if (!$isunknown({status, carryLink})) begin
      if (status.allProp) begin
        a_r3_skip_bypass: assert (carryNext == ~carryLink)
          else $error("skip gate failed to bypass carry");
      end else if (status.gen) begin
        a_r3_skip_generate: assert (carryNext == (KIND == SKIP_OAI))
          else $error("skip gate lost generated carry");
      end
    end
  end

endmodule

// File: rtl/cska_adder.sv
module cska_adder
  import cska_pkg::*;
#(
  parameter int                                  DATA_W      = 32,
  parameter int                                  NUM_STAGES  = 8,
  parameter logic [NUM_STAGES*SIZE_FIELD_W-1:0]  STAGE_SIZES = {8{8'd4}}
) (
  input  logic [DATA_W-1:0] addA,
  input  logic [DATA_W-1:0] addB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut
);

  function automatic int stageWidth(input int k);
    return int'(STAGE_SIZES[k*SIZE_FIELD_W +: SIZE_FIELD_W]);
  endfunction

  function automatic int stageBase(input int k);
    int acc = 0;
    for (int j = 0; j < k; j++) acc += stageWidth(j);
    return acc;
  endfunction

  localparam int TOTAL_W = stageBase(NUM_STAGES);

  if (TOTAL_W != DATA_W) begin : g_bad_sizes
    $error("stage widths do not add up to DATA_W");
  end

  // carryLink[k] enters stage k; polarity alternates at each boundary
  logic [NUM_STAGES:0] carryLink;
  assign carryLink[0] = carryIn;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    localparam int         W    = stageWidth(k);
    localparam int         LO   = stageBase(k);
    localparam int         HI   = LO + W;
    localparam skip_kind_e KIND = (k % 2 == 0) ? SKIP_AOI : SKIP_OAI;

    logic [W-1:0]  sumInt;
    stage_status_t status;

    if (k == 0) begin : g_head
      cska_ripple_block #(.W(W), .HAS_CIN(1'b1)) i_ripple (
        .opA(addA[LO +: W]), .opB(addB[LO +: W]), .carryIn(carryIn),
        .sumInt(sumInt), .status(status)
      );
      assign sumOut[LO +: W] = sumInt;
    end else begin : g_body
      logic trueCarry;
      cska_ripple_block #(.W(W), .HAS_CIN(1'b0)) i_ripple (
        .opA(addA[LO +: W]), .opB(addB[LO +: W]), .carryIn(1'b0),
        .sumInt(sumInt), .status(status)
      );
      // odd stages receive the complemented carry from an AOI below
      assign trueCarry = (KIND == SKIP_OAI) ? ~carryLink[k] : carryLink[k];
      cska_incr_block #(.W(W)) i_incr (
        .sumInt(sumInt), .carryIn(trueCarry), .sumOut(sumOut[LO +: W])
      );
    end

    cska_skip_gate #(.KIND(KIND)) i_skip (
      .status(status), .carryLink(carryLink[k]), .carryNext(carryLink[k+1])
    );

    // R3: each stage's outgoing carry, in true form, matches the prefix sum
    logic [HI:0] refPrefix;
    logic        stageCarry;
    assign refPrefix  = {1'b0, addA[HI-1:0]} + {1'b0, addB[HI-1:0]}
                      + {{HI{1'b0}}, carryIn};
    assign stageCarry = (KIND == SKIP_AOI) ? ~carryLink[k+1] : carryLink[k+1];
    always_comb begin
      if (!$isunknown({addA, addB, carryIn})) begin
        a_r3_stage_carry: assert (stageCarry == refPrefix[HI])
          else $error("stage %0d carry mismatch", k);
      end
    end
  end

  // R7: restore true polarity after an odd number of inverting gates
  if (NUM_STAGES % 2 == 1) begin : g_odd_tail
    assign carryOut = ~carryLink[NUM_STAGES];
  end else begin : g_even_tail
    assign carryOut = carryLink[NUM_STAGES];
  end

  // R1: full-width result against plain arithmetic
  logic [DATA_W:0] refTotal;
  assign refTotal = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, carryIn};
  always_comb begin
    if (!$isunknown({addA, addB, carryIn})) begin
      a_r1_total_sum: assert ({carryOut, sumOut} == refTotal)
        else $error("adder result mismatch");
    end
  end

endmodule

// File: tb/test_cska_adder.sv
module test_cska_adder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  int  total = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  // default: 32 bits, eight 4-bit stages (even count)
  logic [31:0]  a32, b32, s32;
  logic         c32, co32;
  // 128 bits, seven unequal stages (odd count)
  logic [127:0] aW, bW, sW;
  logic         cW, coW;
  // 7 bits, stages 2,3,2 (odd count) for the exhaustive sweep
  logic [6:0]   aS, bS, sS;
  logic         cS, coS;

  cska_adder i_cska_adder (
    .addA(a32), .addB(b32), .carryIn(c32), .sumOut(s32), .carryOut(co32)
  );

  cska_adder #(
    .DATA_W(128), .NUM_STAGES(7),
    .STAGE_SIZES({8'd16, 8'd24, 8'd28, 8'd24, 8'd16, 8'd12, 8'd8})
  ) i_cska_adder_wide (
    .addA(aW), .addB(bW), .carryIn(cW), .sumOut(sW), .carryOut(coW)
  );

  cska_adder #(
    .DATA_W(7), .NUM_STAGES(3),
    .STAGE_SIZES({8'd2, 8'd3, 8'd2})
  ) i_cska_adder_small (
    .addA(aS), .addB(bS), .carryIn(cS), .sumOut(sS), .carryOut(coS)
  );

  task automatic chk(input string req, input logic [128:0] got, input logic [128:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic run32(input string req, input logic [31:0] a, input logic [31:0] b, input logic c);
    @(posedge clk);
    a32 <= a; b32 <= b; c32 <= c;
    @(negedge clk);
    chk(req, 129'({co32, s32}), 129'({1'b0, a} + {1'b0, b} + 33'(c)));
  endtask

  task automatic runW(input string req, input logic [127:0] a, input logic [127:0] b, input logic c);
    @(posedge clk);
    aW <= a; bW <= b; cW <= c;
    @(negedge clk);
    chk(req, {coW, sW}, {1'b0, a} + {1'b0, b} + 129'(c));
  endtask

  initial begin
    a32 = '0; b32 = '0; c32 = 1'b0;
    aW  = '0; bW  = '0; cW  = 1'b0;
    aS  = '0; bS  = '0; cS  = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands give zero result (R5)
    chk("R5 reset zero 32", 129'({co32, s32}), 129'(0));
    chk("R5 reset zero 128", {coW, sW}, 129'(0));
    rst = 1'b0;

    // R5: zero operands
    run32("R5 zero cin1", 32'h0, 32'h0, 1'b1);
    runW ("R5 zero wide cin1", '0, '0, 1'b1);

    // R6: all-ones operands
    run32("R6 ones cin0", '1, '1, 1'b0);
    run32("R6 ones cin1", '1, '1, 1'b1);
    runW ("R6 ones wide cin0", '1, '1, 1'b0);
    runW ("R6 ones wide cin1", '1, '1, 1'b1);

    // R4: all-propagate operands, both carries
    run32("R4 prop cin0", 32'hA5C3_0F96, 32'h5A3C_F069, 1'b0);
    run32("R4 prop cin1", 32'hA5C3_0F96, 32'h5A3C_F069, 1'b1);
    run32("R4 prop plain cin1", 32'hFFFF_FFFF, 32'h0, 1'b1);
    begin
      logic [127:0] r = {$urandom, $urandom, $urandom, $urandom};
      runW("R4 prop wide cin0", r, ~r, 1'b0);
      runW("R4 prop wide cin1", r, ~r, 1'b1);
    end

    // R3: carry made in stage 0 skips propagating stages, lands in stage 7
    run32("R3 long skip", 32'h0FFF_FFF8, 32'h0000_0008, 1'b0);
    run32("R3 skip stops", 32'h00F0_0008, 32'h0000_0008, 1'b0);
    runW ("R3 long skip wide", {4'h0, {123{1'b1}}, 1'b0}, 128'h2, 1'b0);

    // R8: incoming carry ripples through a zero-carry slice
    run32("R8 incr ripple", 32'h0000_007F, 32'h0000_0001, 1'b0);
    run32("R8 incr ripple cin", 32'h0000_0770, 32'h0000_008F, 1'b1);
    runW ("R8 incr ripple wide", 128'h0000_00FF_FFFF, 128'h0000_0000_0001, 1'b0);

    // R7: true-polarity carry-out on odd stage count
    runW("R7 odd count cout1", {1'b1, 127'h0}, {1'b1, 127'h0}, 1'b0);
    runW("R7 odd count cout0", 128'h1, 128'h1, 1'b1);

    // R1: random vectors on the default layout
    for (int n = 0; n < 1500; n++) begin
      run32("R1 random", $urandom, $urandom, 1'($urandom));
    end

    // R2: random vectors on the unequal 128-bit layout
    for (int n = 0; n < 1500; n++) begin
      runW("R2 random wide",
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));
    end

    // R2, R7: exhaustive sweep of the small three-stage layout
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          aS <= 7'(a); bS <= 7'(b); cS <= 1'(c);
          @(negedge clk);
          chk("R2 R7 small sweep", 129'({coS, sS}), 129'(a + b + c));
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule